// File: doc/BRIEF.md
# Infrared SIR Pulse Codec

This block sits between a UART's serial pins and an infrared transceiver. On the transmit side it turns the UART's NRZ bit stream into short optical pulses. A zero bit becomes one active-high pulse at the start of its bit period. A one bit, which covers idle and stop bits, leaves the line dark. On the receive side it turns the pulses seen on the infrared input back into an NRZ bit stream for the UART receiver. When the codec is switched off, both directions pass the raw NRZ signal straight through.

Two pulse-width modes exist. In normal mode a pulse lasts three ticks of the 16x baud tick, which is 3/16 of a bit. In low-power mode a pulse lasts three periods of a separate low-power reference tick, whatever the baud rate. The encoder has no framing knowledge. It finds bit boundaries from transitions on the NRZ input, and between transitions from a count of 16 baud ticks.

Encoder states: `E_MARK` (one bit, dark), `E_PULSE` (pulse driven), `E_SPACE` (rest of a zero bit). Any bit boundary moves the encoder to `E_PULSE` when the new bit is zero and to `E_MARK` when it is one. `E_PULSE` moves to `E_SPACE` on its third reference tick. Decoder states: `D_IDLE`, `D_ARM` (pulse seen at one reference tick) and `D_ZERO` (zero bit reported). `D_IDLE` moves to `D_ARM` when the input is high at a reference tick. `D_ARM` moves to `D_ZERO` when the input is high at the next reference tick, and back to `D_IDLE` if the input drops before then. `D_ZERO` leaves after a bit's worth of baud ticks: it goes to `D_ARM` (chained, still reporting zero) if the input is high at that moment, and to `D_IDLE` otherwise.

Top module: `sir_codec`

## Requirements
- R1: With `sir_en` low, `tx_out` equals `nrz_tx` one clock later, and `rx_out` equals `rx_in` in the same cycle.
- R2: With `sir_en` high, every zero bit on `nrz_tx` gives exactly one high pulse on `tx_out`, starting one clock after the bit begins.
- R3: In normal mode (`lp_sel` = 0) a pulse covers exactly three `tick16` pulses, so it is 3 x (tick spacing) clocks wide when the bit edge coincides with a tick.
- R4: A one bit on `nrz_tx`, including idle and stop bits, gives no pulse. `tx_out` stays low except during pulses.
- R5: In low-power mode (`lp_sel` = 1) a pulse covers exactly three `lp_tick` pulses, whatever the `tick16` spacing.
- R6: A bit period is 16 `tick16` pulses, counted from the last `nrz_tx` transition. Each zero in a run of zeros gets its own pulse.
- R7: A received pulse that is high at two consecutive reference ticks drives `rx_out` low for 15 tick spacings. A further pulse arriving one bit later keeps `rx_out` low without a gap.
- R8: A high level on `rx_in` that does not last from one reference tick to the next leaves `rx_out` high.
- R9: While `rst_n` is low, `tx_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sir_en | input | 1 | 1 = infrared coding, 0 = NRZ pass-through |
| lp_sel | input | 1 | 1 = low-power pulse width from `lp_tick` |
| tick16 | input | 1 | 16x baud tick, one clock wide |
| lp_tick | input | 1 | Low-power reference tick, one clock wide |
| nrz_tx | input | 1 | NRZ transmit bit from the UART |
| rx_in | input | 1 | Infrared receiver input |
| tx_out | output | 1 | Infrared transmit output |
| rx_out | output | 1 | NRZ receive bit to the UART |

## Verification
The hardest case to reach from the ports is the chained decode. In that case a second pulse must be high at the very baud tick on which the decoder's bit-hold count expires, so that `rx_out` stays low across the boundary. The glitch case is also hard: a high level must straddle one reference tick and fall before the next. The bench makes its own `tick16` and drives `rx_in` edges on chosen tick indices, so it places the second pulse exactly 16 ticks after the first and the glitch across a single tick. It then counts the low cycles on `rx_out`.

// File: rtl/sir_pkg.sv
package sir_pkg;
    typedef enum logic [1:0] {
        E_MARK  = 2'd0,
        E_PULSE = 2'd1,
        E_SPACE = 2'd2
    } enc_state_t;

    typedef enum logic [1:0] {
        D_IDLE = 2'd0,
        D_ARM  = 2'd1,
        D_ZERO = 2'd2
    } dec_state_t;
endpackage

// File: rtl/sir_tx_enc.sv
module sir_tx_enc
    import sir_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int PULSE_TICKS   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick16,
    input  logic ref_tick,
    input  logic nrz_tx,
    output logic pulse_nxt
);
    localparam int PW = $clog2(TICKS_PER_BIT);
    localparam int RW = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;
    localparam logic [PW-1:0] PH_LAST = PW'(TICKS_PER_BIT - 1);
    localparam logic [RW-1:0] R_LAST  = RW'(PULSE_TICKS - 1);

    enc_state_t st, nxt;
    logic          nrz_q;
    logic [PW-1:0] ph;
    logic [RW-1:0] rcnt;
    logic          edge_seen, wrap, new_bit;

    assign edge_seen = nrz_tx ^ nrz_q;
    assign wrap      = tick16 && (ph == PH_LAST);
    assign new_bit   = edge_seen || wrap;

    always_comb begin
        nxt = st;
        if (new_bit) begin
            nxt = nrz_tx ? E_MARK : E_PULSE;
        end else begin
            unique case (st)
                E_MARK:  nxt = E_MARK;
                E_PULSE: nxt = (ref_tick && rcnt == R_LAST) ? E_SPACE : E_PULSE;
                E_SPACE: nxt = E_SPACE;
                default: nxt = E_MARK;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= E_MARK;
            nrz_q <= 1'b1;
            ph    <= '0;
            rcnt  <= '0;
        end else if (!en) begin
            st    <= E_MARK;
            nrz_q <= nrz_tx;
            ph    <= '0;
            rcnt  <= '0;
        end else begin
            st    <= nxt;
            nrz_q <= nrz_tx;
            if (edge_seen || wrap)
                ph <= '0;
            else if (tick16)
                ph <= ph + 1'b1;
            if (new_bit)
                rcnt <= '0;
            else if (st == E_PULSE && ref_tick)
                rcnt <= rcnt + 1'b1;
        end
    end

    assign pulse_nxt = en && (nxt == E_PULSE);
endmodule

// File: rtl/sir_rx_dec.sv
module sir_rx_dec
    import sir_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick16,
    input  logic ref_tick,
    input  logic rx_in,
    output logic zero_out
);
    localparam int HW = $clog2(TICKS_PER_BIT);
    localparam logic [HW-1:0] H_LAST = HW'(TICKS_PER_BIT - 1);

    dec_state_t st, nxt;
    logic          chain, chain_nxt;
    logic [HW-1:0] hcnt;
    logic          term;

    assign term = tick16 && (hcnt == H_LAST);

    always_comb begin
        nxt       = st;
        chain_nxt = chain;
        unique case (st)
            D_IDLE: begin
                if (ref_tick && rx_in) begin
                    nxt       = D_ARM;
                    chain_nxt = 1'b0;
                end
            end
            D_ARM: begin
                if (!rx_in) begin
                    nxt       = D_IDLE;
                    chain_nxt = 1'b0;
                end else if (ref_tick) begin
                    nxt = D_ZERO;
                end
            end
            D_ZERO: begin
                if (term) begin
                    nxt       = rx_in ? D_ARM : D_IDLE;
                    chain_nxt = rx_in;
                end
            end
            default: begin
                nxt       = D_IDLE;
                chain_nxt = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= D_IDLE;
            chain <= 1'b0;
            hcnt  <= '0;
        end else if (!en) begin
            st    <= D_IDLE;
            chain <= 1'b0;
            hcnt  <= '0;
        end else begin
            st    <= nxt;
            chain <= chain_nxt;
            if (nxt == D_ARM && st != D_ARM)
                hcnt <= '0;
            else if (tick16 && st != D_IDLE)
                hcnt <= hcnt + 1'b1;
        end
    end

    always_comb begin
        zero_out = (st == D_ZERO) || (st == D_ARM && chain);
    end

    // R8: a new detection from idle never reports a zero in the next cycle
    property p_glitch_quiet_r8;
        @(posedge clk) disable iff (!rst_n)
        (en && st == D_IDLE) |=> (!en || !zero_out);
    endproperty
    assert property (p_glitch_quiet_r8);

    // R7: zero is held through every non-tick cycle of the hold window
    property p_zero_hold_r7;
        @(posedge clk) disable iff (!rst_n)
        (en && st == D_ZERO && !tick16) |=> (!en || zero_out);
    endproperty
    assert property (p_zero_hold_r7);
endmodule

// File: rtl/sir_codec.sv
module sir_codec
    import sir_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int PULSE_TICKS   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sir_en,
    input  logic lp_sel,
    input  logic tick16,
    input  logic lp_tick,
    input  logic nrz_tx,
    input  logic rx_in,
    output logic tx_out,
    output logic rx_out
);
    logic ref_tick;
    logic enc_pulse_nxt;
    logic dec_zero;
    logic tx_q;

    assign ref_tick = lp_sel ? lp_tick : tick16;

    sir_tx_enc #(
        .TICKS_PER_BIT(TICKS_PER_BIT),
        .PULSE_TICKS  (PULSE_TICKS)
    ) u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (sir_en),
        .tick16   (tick16),
        .ref_tick (ref_tick),
        .nrz_tx   (nrz_tx),
        .pulse_nxt(enc_pulse_nxt)
    );

    sir_rx_dec #(
        .TICKS_PER_BIT(TICKS_PER_BIT)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (sir_en),
        .tick16  (tick16),
        .ref_tick(ref_tick),
        .rx_in   (rx_in),
        .zero_out(dec_zero)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tx_q <= 1'b0;
        else
            tx_q <= sir_en ? enc_pulse_nxt : nrz_tx;
    end

    assign tx_out = tx_q;
    assign rx_out = sir_en ? !dec_zero : rx_in;

    // R1: pass-through with one clock of latency when coding is off
    property p_bypass_r1;
        @(posedge clk) disable iff (!rst_n)
        !sir_en |=> (tx_out == $past(nrz_tx));
    endproperty
    assert property (p_bypass_r1);

    // R4: a lit output always belongs to a zero bit
    property p_dark_one_r4;
        @(posedge clk) disable iff (!rst_n)
        (sir_en && $past(sir_en) && tx_out) |-> !$past(nrz_tx);
    endproperty
    assert property (p_dark_one_r4);

    // R9: output dark in reset
    property p_reset_dark_r9;
        @(posedge clk) !rst_n |=> !tx_out;
    endproperty
    assert property (p_reset_dark_r9);
endmodule

// File: tb/test_sir_codec.sv
`timescale 1ns/1ps
module test_sir_codec;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sir_en = 1'b0;
    logic lp_sel = 1'b0;
    logic tick16 = 1'b0;
    logic lp_tick = 1'b0;
    logic nrz_tx = 1'b1;
    logic rx_in = 1'b0;
    logic tx_out, rx_out;

    always #2 clk = ~clk;

    sir_codec i_sir_codec (
        .clk(clk), .rst_n(rst_n), .sir_en(sir_en), .lp_sel(lp_sel),
        .tick16(tick16), .lp_tick(lp_tick), .nrz_tx(nrz_tx), .rx_in(rx_in),
        .tx_out(tx_out), .rx_out(rx_out)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // low-power reference: one tick every 3 clocks
    int lpc = 0;
    always @(negedge clk) begin
        lpc = (lpc == 2) ? 0 : lpc + 1;
        lp_tick <= (lpc == 0);
    end

    // monitor
    logic prev_tx = 1'b0;
    int cur_w = 0, cur_t = 0, npulse = 0, wmin = 0, wmax = 0, tbad = 0, rxlow = 0;
    always @(posedge clk) begin
        #1;
        if (prev_tx && (lp_sel ? lp_tick : tick16)) cur_t++;
        if (tx_out) cur_w++;
        if (prev_tx && !tx_out) begin
            npulse++;
            if (npulse == 1 || cur_w < wmin) wmin = cur_w;
            if (cur_w > wmax) wmax = cur_w;
            if (cur_t != 3) tbad++;
            cur_w = 0;
            cur_t = 0;
        end
        if (!rx_out) rxlow++;
        prev_tx = tx_out;
    end

    task automatic clear_mon();
        npulse = 0; wmin = 0; wmax = 0; tbad = 0; rxlow = 0; cur_w = 0; cur_t = 0;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic send_bit(input logic b, input int per);
        for (int t = 0; t < 16; t++) begin
            for (int c = 0; c < per; c++) begin
                @(negedge clk);
                tick16 = (c == 0);
                if (t == 0 && c == 0) nrz_tx = b;
            end
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input int per);
        send_bit(1'b1, per);
        send_bit(1'b1, per);
        send_bit(1'b0, per);
        for (int i = 0; i < 8; i++) send_bit(d[i], per);
        send_bit(1'b1, per);
        send_bit(1'b1, per);
    endtask

    // rx stimulus: mode 0 single pulse, 1 double pulse, 2 glitch
    task automatic rx_run(input int mode, input int per);
        for (int t = 0; t < 48; t++) begin
            for (int c = 0; c < per; c++) begin
                @(negedge clk);
                tick16 = (c == 0);
                if (mode == 2)
                    rx_in = (t == 2 && c < 2);
                else
                    rx_in = (t >= 2 && t <= 4) || (mode == 1 && t >= 18 && t <= 20);
            end
        end
        @(negedge clk);
        tick16 = 1'b0;
        rx_in = 1'b0;
    endtask

    // {lp_sel, tick spacing, data byte}
    localparam logic [12:0] VEC [5] = '{
        {1'b0, 4'd4, 8'h55},
        {1'b0, 4'd5, 8'h00},
        {1'b0, 4'd4, 8'hFF},
        {1'b1, 4'd4, 8'hA3},
        {1'b1, 4'd7, 8'h0F}
    };

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_up();
    end

    initial begin
        // R9: reset keeps output dark even with nrz high
        repeat (3) @(negedge clk);
        check(tx_out == 1'b0, "R9 reset", tx_out, 0);
        rst_n = 1'b1;

        // R1: pass-through
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            nrz_tx = i[0];
            rx_in = ~i[0];
            @(posedge clk);
            #1;
            check(tx_out == nrz_tx, "R1 tx bypass", tx_out, nrz_tx);
            check(rx_out == rx_in, "R1 rx bypass", rx_out, rx_in);
        end
        @(negedge clk);
        nrz_tx = 1'b1;
        rx_in = 1'b0;
        sir_en = 1'b1;
        repeat (4) @(negedge clk);

        // vector table: R2 R3 R4 R5 R6
        foreach (VEC[k]) begin
            int per, zeros, exp_p;
            logic [7:0] d;
            lp_sel = VEC[k][12];
            per = int'(VEC[k][11:8]);
            d = VEC[k][7:0];
            zeros = 0;
            for (int i = 0; i < 8; i++) if (!d[i]) zeros++;
            exp_p = 1 + zeros;
            clear_mon();
            send_frame(d, per);
            repeat (4) @(negedge clk);
            check(npulse == exp_p, "R2/R4/R6 pulse count", npulse, exp_p);
            check(tbad == 0, lp_sel ? "R5 lp ticks per pulse" : "R3 ticks per pulse", tbad, 0);
            if (!lp_sel) begin
                check(wmin == 3 * per && wmax == 3 * per, "R3 width", wmax, 3 * per);
            end else begin
                check(wmin >= 7 && wmax <= 9, "R5 width", wmax, 9);
            end
            check(tx_out == 1'b0, "R4 idle dark", tx_out, 0);
        end

        // R7 single and chained receive, R8 glitch
        lp_sel = 1'b0;
        clear_mon();
        rx_run(0, 4);
        check(rxlow == 60, "R7 single zero", rxlow, 60);
        clear_mon();
        rx_run(1, 4);
        check(rxlow == 124, "R7 chained zero", rxlow, 124);
        clear_mon();
        rx_run(2, 4);
        check(rxlow == 0, "R8 glitch", rxlow, 0);

        // R9: reset mid-pulse forces output low
        @(negedge clk);
        nrz_tx = 1'b0;
        tick16 = 1'b1;
        @(negedge clk);
        tick16 = 1'b0;
        @(negedge clk);
        check(tx_out == 1'b1, "R2 pulse lit", tx_out, 1);
        rst_n = 1'b0;
        #1;
        check(tx_out == 1'b0, "R9 reset mid-pulse", tx_out, 0);

        finish_up();
    end
endmodule